// File: doc/BRIEF.md
# Dual-Issue Instruction Queue Dispatcher

This block sits at the front of a small two-way superscalar core. A fetch stage offers up to two instructions per cycle on two lanes that share one ready signal. Accepted instructions are held in a circular queue in program order. From the head of that queue the block sends up to two instructions per cycle to two execution units: an arithmetic unit with one stage and a load/store unit with two stages.

Each instruction carries a one-bit unit-class field and a destination-register field. The block reads only those two fields. The class picks the issue port. The two head instructions leave together only when they need different units and write different registers. Otherwise only the older one leaves, and the younger one becomes the new head.

The load/store unit is pipelined, so both issue ports can take a new instruction every cycle. The issue ports therefore have no back-pressure and carry only a valid bit. The fetch side is valid/ready. An instruction on a lane moves into the queue on a clock edge where both its valid and `fetch_ready` are high. `fetch_ready` is a function of the queue fill and `flush` only, so it never depends on the fetch valids. A flush clears the queue in one cycle.

Top module: `dual_issue_dispatch`

## Requirements
- R1: After reset the queue is empty, both issue valids are low and `fetch_ready` is high.
- R2: `fetch_ready` is high exactly when at least two queue slots are free and `flush` is low (with the default depth of 8, when at most 6 entries are held). On a ready edge every valid lane is enqueued. Lane 0 is older than lane 1, and lane 1 alone is accepted when lane 0 is idle.
- R3: Instructions issue in the order they were accepted. The second head entry never issues unless the first one issues in the same cycle.
- R4: The class bit (bit 0) steers each instruction. A value of 0 goes to the arithmetic port and 1 goes to the load/store port. The instruction word reaches the port unchanged.
- R5: When the two head entries have different classes and different destination fields, both issue in the same cycle.
- R6: When the two head entries have the same class, only the older one issues. The younger one becomes the head and may pair with the entry behind it in the next cycle.
- R7: When the two head entries have equal destination fields (bits 11:7), only the older one issues, whatever their classes.
- R8: The load/store port can present a new valid instruction in consecutive cycles.
- R9: While `flush` is high, nothing issues and `fetch_ready` is low. The queue is empty in the following cycle.
- R10: An instruction accepted on an edge can appear on its issue port in the very next cycle. The issue ports are driven combinationally from the queue head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty the queue and suppress issue this cycle |
| fetch_valid0 | input | 1 | Lane 0 (older) carries an instruction |
| fetch_instr0 | input | INSTR_W | Lane 0 instruction word |
| fetch_valid1 | input | 1 | Lane 1 (younger) carries an instruction |
| fetch_instr1 | input | INSTR_W | Lane 1 instruction word |
| fetch_ready | output | 1 | Both lanes may be accepted this cycle |
| alu_valid | output | 1 | Arithmetic issue slot holds an instruction |
| alu_instr | output | INSTR_W | Instruction sent to the arithmetic unit |
| lsu_valid | output | 1 | Load/store issue slot holds an instruction |
| lsu_instr | output | INSTR_W | Instruction sent to the load/store unit |

## Verification
The pairing logic is exercised with head pairs of mixed classes in both orders, same-class pairs of each kind, and destination clashes across and within classes. Together these separate the class rule from the register rule, and check that the older entry always wins. A split followed by a fresh arrival shows that the leftover entry pairs with a newer one. A stream of arithmetic-only instructions, which drains one entry per cycle while two arrive, drives the queue into the back-pressure threshold and checks program order across pointer wrap-around. A flush with a non-empty queue checks that issue is suppressed and that the queue comes back empty.

// File: rtl/iq_pkg.sv
package iq_pkg;
  // Unit class carried in the instruction's class bit.
  typedef enum logic {
    UC_ALU = 1'b0,
    UC_LSU = 1'b1
  } unit_cls_e;

  localparam int NUM_UNITS = 2;
  localparam int ALU_IDX   = 0;  // equals the class value of UC_ALU
  localparam int LSU_IDX   = 1;  // equals the class value of UC_LSU
endpackage

// File: rtl/iq_ring.sv
module iq_ring #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         wen0,
  input  logic [W-1:0]                 wdata0,
  input  logic                         wen1,
  input  logic [W-1:0]                 wdata1,
  input  logic [1:0]                   pop_n,
  output logic [W-1:0]                 head0,
  output logic [W-1:0]                 head1,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [1:0]       push_n;
  logic [W-1:0]     first_data;

  function automatic logic [PTR_W-1:0] wrap_add(input logic [PTR_W-1:0] p,
                                                input logic [1:0] s);
    int unsigned t;
    t = int'(p) + int'(s);
    if (t >= DEPTH) t = t - DEPTH;
    return PTR_W'(t);
  endfunction

  assign push_n     = {1'b0, wen0} + {1'b0, wen1};
  assign first_data = wen0 ? wdata0 : wdata1;   // compact a lone lane 1

  always_ff @(posedge clk) begin
    if (!flush) begin
      if (wen0 || wen1) mem[wr_ptr] <= first_data;
      if (wen0 && wen1) mem[wrap_add(wr_ptr, 2'd1)] <= wdata1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      rd_ptr <= wrap_add(rd_ptr, pop_n);
      wr_ptr <= wrap_add(wr_ptr, push_n);
      count  <= count + CNT_W'(push_n) - CNT_W'(pop_n);
    end
  end

  assign head0 = mem[rd_ptr];
  assign head1 = mem[wrap_add(rd_ptr, 2'd1)];

  // R2: occupancy never passes the depth
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R3: never remove more than is held
  p_pop_within_r3: assert property (@(posedge clk) disable iff (!rst_n)
    CNT_W'(pop_n) <= count);
endmodule

// File: rtl/iq_pair_pick.sv
module iq_pair_pick #(
  parameter int W         = 32,
  parameter int CLASS_BIT = 0,
  parameter int DEST_LSB  = 7,
  parameter int REG_W     = 5
) (
  input  logic         flush,
  input  logic         have_one,
  input  logic         have_two,
  input  logic [W-1:0] head0,
  input  logic [W-1:0] head1,
  output logic         take0,
  output logic         take1,
  output logic [1:0]   pop_n
);
  logic same_cls, same_dst;

  assign same_cls = head0[CLASS_BIT] == head1[CLASS_BIT];
  assign same_dst = head0[DEST_LSB +: REG_W] == head1[DEST_LSB +: REG_W];

  // The older entry always goes first; the younger only rides along.
  assign take0 = !flush && have_one;
  assign take1 = take0 && have_two && !same_cls && !same_dst;
  assign pop_n = take1 ? 2'd2 : (take0 ? 2'd1 : 2'd0);
endmodule

// File: rtl/iq_steer.sv
module iq_steer #(
  parameter int W         = 32,
  parameter int CLASS_BIT = 0
) (
  input  logic                               take0,
  input  logic                               take1,
  input  logic [W-1:0]                       head0,
  input  logic [W-1:0]                       head1,
  output logic [iq_pkg::NUM_UNITS-1:0]       unit_valid,
  output logic [iq_pkg::NUM_UNITS-1:0][W-1:0] unit_instr
);
  for (genvar u = 0; u < iq_pkg::NUM_UNITS; u++) begin : g_unit
    localparam logic CLS = (u == iq_pkg::LSU_IDX);
    logic sel0, sel1;
    assign sel0 = take0 && (head0[CLASS_BIT] == CLS);
    assign sel1 = take1 && (head1[CLASS_BIT] == CLS);
    assign unit_valid[u] = sel0 || sel1;
    assign unit_instr[u] = sel0 ? head0 : (sel1 ? head1 : '0);
  end
endmodule

// File: rtl/dual_issue_dispatch.sv
module dual_issue_dispatch #(
  parameter int INSTR_W   = 32,
  parameter int DEPTH     = 8,
  parameter int CLASS_BIT = 0,
  parameter int DEST_LSB  = 7,
  parameter int REG_W     = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               fetch_valid0,
  input  logic [INSTR_W-1:0] fetch_instr0,
  input  logic               fetch_valid1,
  input  logic [INSTR_W-1:0] fetch_instr1,
  output logic               fetch_ready,
  output logic               alu_valid,
  output logic [INSTR_W-1:0] alu_instr,
  output logic               lsu_valid,
  output logic [INSTR_W-1:0] lsu_instr
);
  import iq_pkg::*;

  localparam int CNT_W = $clog2(DEPTH+1);

  logic [CNT_W-1:0]                     count;
  logic [INSTR_W-1:0]                   head0, head1;
  logic                                 take0, take1;
  logic [1:0]                           pop_n;
  logic [NUM_UNITS-1:0]                 unit_valid;
  logic [NUM_UNITS-1:0][INSTR_W-1:0]    unit_instr;

  // Ready needs room for a full pair; it does not look at the valids.
  assign fetch_ready = !flush && (count <= CNT_W'(DEPTH-2));

  iq_ring #(.W(INSTR_W), .DEPTH(DEPTH)) u_ring (
    .clk    (clk),
    .rst_n  (rst_n),
    .flush  (flush),
    .wen0   (fetch_ready && fetch_valid0),
    .wdata0 (fetch_instr0),
    .wen1   (fetch_ready && fetch_valid1),
    .wdata1 (fetch_instr1),
    .pop_n  (pop_n),
    .head0  (head0),
    .head1  (head1),
    .count  (count)
  );

  iq_pair_pick #(.W(INSTR_W), .CLASS_BIT(CLASS_BIT), .DEST_LSB(DEST_LSB),
                 .REG_W(REG_W)) u_pick (
    .flush    (flush),
    .have_one (count != '0),
    .have_two (count >= CNT_W'(2)),
    .head0    (head0),
    .head1    (head1),
    .take0    (take0),
    .take1    (take1),
    .pop_n    (pop_n)
  );

  iq_steer #(.W(INSTR_W), .CLASS_BIT(CLASS_BIT)) u_steer (
    .take0      (take0),
    .take1      (take1),
    .head0      (head0),
    .head1      (head1),
    .unit_valid (unit_valid),
    .unit_instr (unit_instr)
  );

  assign alu_valid = unit_valid[ALU_IDX];
  assign alu_instr = unit_instr[ALU_IDX];
  assign lsu_valid = unit_valid[LSU_IDX];
  assign lsu_instr = unit_instr[LSU_IDX];

  // R4: each port only ever carries its own class
  p_alu_class_r4: assert property (@(posedge clk) disable iff (!rst_n)
    alu_valid |-> (alu_instr[CLASS_BIT] == UC_ALU));
  p_lsu_class_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lsu_valid |-> (lsu_instr[CLASS_BIT] == UC_LSU));

  // R7: a dual issue never has two writers of one register
  p_dest_distinct_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_valid && lsu_valid) |->
      (alu_instr[DEST_LSB +: REG_W] != lsu_instr[DEST_LSB +: REG_W]));

  // R9: flush blocks issue and leaves the queue empty
  p_flush_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!alu_valid && !lsu_valid && !fetch_ready));
  p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));

  // R3: nothing issues from an empty queue
  p_issue_needs_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_valid || lsu_valid) |-> (count != '0));
endmodule

// File: tb/test_dual_issue_dispatch.sv
`timescale 1ns/1ps
module test_dual_issue_dispatch;
  localparam int W     = 32;
  localparam int DEPTH = 8;
  localparam int NV    = 6;

  // Vector: {older, younger, first-cycle {lsu,alu}, second-cycle {lsu,alu}}
  // Word layout: [31:16] tag, [11:7] destination, [0] class (1 = load/store)
  localparam logic [W+W+4-1:0] VEC [NV] = '{
    {32'h0001_0080, 32'h0002_0101, 2'b11, 2'b00},  // R5 alu+lsu
    {32'h0003_0081, 32'h0004_0100, 2'b11, 2'b00},  // R5 lsu+alu
    {32'h0005_0080, 32'h0006_0100, 2'b01, 2'b01},  // R6 alu,alu
    {32'h0007_0081, 32'h0008_0181, 2'b10, 2'b10},  // R6 lsu,lsu (R8)
    {32'h0009_0180, 32'h000A_0181, 2'b01, 2'b10},  // R7 same dest
    {32'h000B_0101, 32'h000C_0100, 2'b10, 2'b01}   // R7 same dest
  };

  logic clk = 1'b0;
  logic rst_n, flush;
  logic fetch_valid0, fetch_valid1, fetch_ready;
  logic [W-1:0] fetch_instr0, fetch_instr1;
  logic alu_valid, lsu_valid;
  logic [W-1:0] alu_instr, lsu_instr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  dual_issue_dispatch #(.INSTR_W(W), .DEPTH(DEPTH)) i_dual_issue_dispatch (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .fetch_valid0(fetch_valid0), .fetch_instr0(fetch_instr0),
    .fetch_valid1(fetch_valid1), .fetch_instr1(fetch_instr1),
    .fetch_ready(fetch_ready),
    .alu_valid(alu_valid), .alu_instr(alu_instr),
    .lsu_valid(lsu_valid), .lsu_instr(lsu_instr)
  );

  task automatic check(input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  function automatic string req_of(input int k);
    if (k < 2) return "R5";
    if (k < 4) return "R6";
    return "R7";
  endfunction

  function automatic logic [W-1:0] mk_alu(input int id);
    return {id[15:0], 16'h0080};
  endfunction

  task automatic idle_inputs();
    fetch_valid0 = 1'b0; fetch_valid1 = 1'b0; flush = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] i0, i1;
    logic [1:0] e1, e2;
    int cnt, next_push, next_pop;
    bit exp_rdy;

    rst_n = 1'b0; idle_inputs();
    fetch_instr0 = '0; fetch_instr1 = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    check("R1 ready", {63'd0, fetch_ready}, 64'd1);
    check("R1 valids", {62'd0, lsu_valid, alu_valid}, 64'd0);

    // Table walk: push a pair into an empty queue, watch it drain.
    for (int k = 0; k < NV; k++) begin
      {i0, i1, e1, e2} = VEC[k];
      @(negedge clk);
      fetch_valid0 = 1'b1; fetch_instr0 = i0;
      fetch_valid1 = 1'b1; fetch_instr1 = i1;
      @(negedge clk); idle_inputs(); #1;
      // R10: visible one cycle after acceptance
      check({req_of(k), " first"}, {62'd0, lsu_valid, alu_valid}, {62'd0, e1});
      if (e1[0]) check("R4 alu port", {32'd0, alu_instr},
                       {32'd0, (i0[0] == 1'b0) ? i0 : i1});
      if (e1[1]) check("R4 lsu port", {32'd0, lsu_instr},
                       {32'd0, (i0[0] == 1'b1) ? i0 : i1});
      @(negedge clk); #1;
      check({req_of(k), " second"}, {62'd0, lsu_valid, alu_valid}, {62'd0, e2});
      if (e2 != 2'b00)
        check("R3 younger follows", {32'd0, i1[0] ? lsu_instr : alu_instr},
              {32'd0, i1});
      @(negedge clk); #1;
      check("R3 drained", {62'd0, lsu_valid, alu_valid}, 64'd0);
    end

    // R2: lane 1 alone is accepted
    @(negedge clk);
    fetch_valid1 = 1'b1; fetch_instr1 = 32'h0020_0200;
    @(negedge clk); idle_inputs(); #1;
    check("R2 lone lane1", {31'd0, alu_valid, alu_instr}, {31'd0, 1'b1, 32'h0020_0200});
    @(negedge clk); #1;

    // R6/R8: split pair, leftover pairs with a newer entry
    @(negedge clk);
    fetch_valid0 = 1'b1; fetch_instr0 = 32'h0030_0081;  // lsu d1
    fetch_valid1 = 1'b1; fetch_instr1 = 32'h0031_0101;  // lsu d2
    @(negedge clk);
    fetch_valid0 = 1'b1; fetch_instr0 = 32'h0032_0180;  // alu d3
    fetch_valid1 = 1'b0; #1;
    check("R6 older only", {30'd0, lsu_valid, alu_valid, lsu_instr},
          {30'd0, 2'b10, 32'h0030_0081});
    @(negedge clk); idle_inputs(); #1;
    check("R8 lsu back to back", {31'd0, lsu_valid, lsu_instr},
          {31'd0, 1'b1, 32'h0031_0101});
    check("R6 leftover pairs", {31'd0, alu_valid, alu_instr},
          {31'd0, 1'b1, 32'h0032_0180});
    @(negedge clk); #1;
    check("R3 empty after pair", {62'd0, lsu_valid, alu_valid}, 64'd0);

    // R2/R3: arithmetic-only stream fills the queue, order kept
    cnt = 0; next_push = 100; next_pop = 100;
    for (int c = 0; c < 14; c++) begin
      @(negedge clk);
      fetch_valid0 = 1'b1; fetch_instr0 = mk_alu(next_push);
      fetch_valid1 = 1'b1; fetch_instr1 = mk_alu(next_push + 1); #1;
      exp_rdy = (cnt <= DEPTH - 2);
      check("R2 ready threshold", {63'd0, fetch_ready}, {63'd0, exp_rdy});
      if (cnt >= 1) begin
        check("R3 order", {47'd0, alu_valid, alu_instr[31:16]},
              {47'd0, 1'b1, next_pop[15:0]});
        next_pop++; cnt--;
      end
      if (exp_rdy) begin next_push += 2; cnt += 2; end
    end
    @(negedge clk); idle_inputs();
    for (int c = 0; c < 2*DEPTH && cnt > 0; c++) begin
      #1;
      check("R3 drain order", {47'd0, alu_valid, alu_instr[31:16]},
            {47'd0, 1'b1, next_pop[15:0]});
      next_pop++; cnt--;
      @(negedge clk);
    end
    #1;
    check("R3 stream empty", {62'd0, lsu_valid, alu_valid}, 64'd0);

    // R9: flush with a held pair
    @(negedge clk);
    fetch_valid0 = 1'b1; fetch_instr0 = 32'h0040_0080;
    fetch_valid1 = 1'b1; fetch_instr1 = 32'h0041_0100;
    @(negedge clk); idle_inputs(); flush = 1'b1; #1;
    check("R9 no issue", {61'd0, fetch_ready, lsu_valid, alu_valid}, 64'd0);
    @(negedge clk); flush = 1'b0; #1;
    check("R9 emptied", {61'd0, fetch_ready, lsu_valid, alu_valid}, 64'd4);

    finish_run();
  end
endmodule